// File: doc/BRIEF.md
# Instruction Length Decoder

This block looks at a window of up to fifteen bytes that begins at the first byte of an instruction. It works out how many bytes the instruction occupies. It walks the fields in their fixed order: any prefix bytes, an opcode of one to three bytes, an optional ModR/M byte, an optional SIB byte, a displacement and an immediate. The size of each field depends on the opcode, on the mode and r/m fields of the ModR/M byte, on the base field of the SIB byte and on the operand-size and address-size override prefixes.

A fetch or predecode stage presents a window with `in_valid`. One clock later the block returns the length, the prefix count, the size of every field and one flag for each prefix class it saw. Windows that cannot form a legal instruction are flagged. Only a defined subset of opcodes is known to the property table, and any other opcode is reported as unsupported. Opcode meaning, execution and 64-bit register-extension prefixes are not handled.

Top module: `insn_len_decoder`

## Requirements
- R1: While `rst` is high, every output register is cleared to zero after the next rising edge.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. The other outputs are updated only for an accepted window.
- R3: Leading bytes 26h, 2Eh, 36h, 3Eh, 64h and 65h (segment override), 66h (operand size), 67h (address size), F0h (lock), F2h and F3h (repeat) are counted in `out_pfx_cnt`. Each sets its own flag: `out_seg_ovr`, `out_opsize`, `out_adsize`, `out_lock` or `out_rep`.
- R4: An opcode that starts with 0Fh is two bytes long (`out_op_bytes`=2). 0Fh 38h xx and 0Fh 3Ah xx are three bytes long, always take a ModR/M byte, and 0Fh 3Ah adds a 1-byte immediate.
- R5: The ModR/M byte is split as mod in bits 7..6, reg in bits 5..3 and r/m in bits 2..0. With 32-bit addressing a SIB byte (base in bits 2..0) follows when mod is not 11b and r/m is 100b.
- R6: With 32-bit addressing, mod=01b gives a 1-byte displacement and mod=10b gives a 4-byte displacement. mod=00b gives a 4-byte displacement when r/m=101b, or when r/m=100b and the SIB base is 101b, and none otherwise. mod=11b gives none.
- R7: After an address-size override, 16-bit addressing applies: there is never a SIB byte, mod=01b gives 1 byte, and mod=10b, or mod=00b with r/m=110b, gives 2 bytes.
- R8: Known one-byte opcodes: 00h-3Fh ALU (low bits 0-3 ModR/M, 4 imm8, 5 full imm, 6-7 bare); 40h-5Fh, 90h-97h, C3h, CCh, F4h, F5h, F8h-FDh bare; 68h, A9h, B8h-BFh, E8h, E9h full imm; 6Ah, 70h-7Fh, A8h, B0h-B7h, CDh, EBh imm8; C2h imm16; 69h, 81h, C7h ModR/M plus full imm; 6Bh, 80h, 83h, C6h ModR/M plus imm8; 84h-8Fh, FEh, FFh ModR/M only.
- R9: Known two-byte opcodes after 0Fh: 05h, 31h, A2h bare; 80h-8Fh full imm; 1Fh, 40h-4Fh, 90h-9Fh, AFh, B6h, B7h, BEh, BFh ModR/M only.
- R10: A full immediate is 4 bytes, or 2 bytes after an operand-size override. imm8 and the imm16 of C2h do not change.
- R11: F6h takes an imm8 and F7h a full immediate only when the ModR/M reg field is 000b. Otherwise they take no immediate.
- R12: `out_len` is the sum of all field sizes. A total of up to 15 is legal, and a total above 15 sets `out_illegal` and reports length 0.
- R13: A window of fifteen prefix bytes with no opcode sets `out_illegal` with `out_pfx_cnt`=15 and length 0.
- R14: An opcode outside R4, R8 and R9 sets `out_unsupported` and reports length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window present this cycle |
| in_bytes | input | 120 | Window, byte k at bits 8k+7..8k |
| out_valid | output | 1 | Result present |
| out_len | output | 4 | Instruction length in bytes, 0 when flagged |
| out_pfx_cnt | output | 4 | Number of prefix bytes |
| out_op_bytes | output | 2 | Opcode length |
| out_has_modrm | output | 1 | ModR/M byte present |
| out_has_sib | output | 1 | SIB byte present |
| out_disp_bytes | output | 3 | Displacement size |
| out_imm_bytes | output | 3 | Immediate size |
| out_seg_ovr | output | 1 | Segment override seen |
| out_opsize | output | 1 | Operand-size override seen |
| out_adsize | output | 1 | Address-size override seen |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 1 | Repeat prefix seen |
| out_illegal | output | 1 | Over 15 bytes or no opcode |
| out_unsupported | output | 1 | Opcode not in the table |

## Verification
All results belong to the window accepted at a rising edge and appear at that same edge's register outputs, one cycle after `in_valid` is raised. `out_valid` falls one edge after `in_valid` falls. The bench drives each window on a falling edge, holds it across one rising edge and reads every field at the next falling edge. It then lowers `in_valid` and reads `out_valid` one cycle later. This keeps every sample half a period away from the edge that updates the outputs.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_BYTE = 2'd1,
    IMM_WORD = 2'd2,
    IMM_FULL = 2'd3
  } imm_kind_e;

  typedef struct packed {
    logic      known;
    logic [1:0] op_len;
    logic      has_modrm;
    imm_kind_e imm;
    logic      imm_reg0;
  } op_info_t;

  typedef struct packed {
    logic seg;
    logic opsz;
    logic adsz;
    logic lock;
    logic rep;
  } pfx_flags_t;

  localparam logic [7:0] PFX_OPSZ  = 8'h66;
  localparam logic [7:0] PFX_ADSZ  = 8'h67;
  localparam logic [7:0] PFX_LOCK  = 8'hF0;
  localparam logic [7:0] PFX_REPNZ = 8'hF2;
  localparam logic [7:0] PFX_REPZ  = 8'hF3;
  localparam logic [7:0] ESC_TWO   = 8'h0F;
  localparam logic [7:0] ESC_38    = 8'h38;
  localparam logic [7:0] ESC_3A    = 8'h3A;

  function automatic logic is_seg_pfx(input logic [7:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) ||
           (b == 8'h3E) || (b == 8'h64) || (b == 8'h65);
  endfunction

  function automatic logic is_any_pfx(input logic [7:0] b);
    return is_seg_pfx(b) || (b == PFX_OPSZ) || (b == PFX_ADSZ) ||
           (b == PFX_LOCK) || (b == PFX_REPNZ) || (b == PFX_REPZ);
  endfunction

endpackage

// File: rtl/ild_prefix_scan.sv
module ild_prefix_scan import ild_pkg::*; #(
  parameter int MAX_BYTES = 15,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic [MAX_BYTES*8-1:0] bytes_i,
  output logic [CNT_W-1:0]       count_o,
  output pfx_flags_t             flags_o
);

  logic [MAX_BYTES-1:0] hit;
  logic [MAX_BYTES-1:0] run;

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
    assign hit[i] = is_any_pfx(bytes_i[i*8 +: 8]);
    if (i == 0) begin : g_first
      assign run[i] = hit[i];
    end else begin : g_rest
      assign run[i] = run[i-1] & hit[i];
    end
  end

  always_comb begin
    count_o = '0;
    flags_o = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (run[i]) begin
        count_o = count_o + CNT_W'(1);
        if (is_seg_pfx(bytes_i[i*8 +: 8]))     flags_o.seg  = 1'b1;
        if (bytes_i[i*8 +: 8] == PFX_OPSZ)     flags_o.opsz = 1'b1;
        if (bytes_i[i*8 +: 8] == PFX_ADSZ)     flags_o.adsz = 1'b1;
        if (bytes_i[i*8 +: 8] == PFX_LOCK)     flags_o.lock = 1'b1;
        if ((bytes_i[i*8 +: 8] == PFX_REPNZ) ||
            (bytes_i[i*8 +: 8] == PFX_REPZ))   flags_o.rep  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ild_opcode_props.sv
module ild_opcode_props import ild_pkg::*; (
  input  logic [7:0] op0_i,
  input  logic [7:0] op1_i,
  output op_info_t   info_o
);

  always_comb begin
    info_o = '0;
    if (op0_i == ESC_TWO) begin
      info_o.op_len = 2'd2;
      if (op1_i == ESC_38) begin
        info_o.known = 1'b1; info_o.op_len = 2'd3; info_o.has_modrm = 1'b1;
      end else if (op1_i == ESC_3A) begin
        info_o.known = 1'b1; info_o.op_len = 2'd3; info_o.has_modrm = 1'b1;
        info_o.imm = IMM_BYTE;
      end else if (op1_i == 8'h05 || op1_i == 8'h31 || op1_i == 8'hA2) begin
        info_o.known = 1'b1;
      end else if (op1_i[7:4] == 4'h8) begin
        info_o.known = 1'b1; info_o.imm = IMM_FULL;
      end else if (op1_i == 8'h1F || op1_i[7:4] == 4'h4 || op1_i[7:4] == 4'h9 ||
                   op1_i == 8'hAF || op1_i == 8'hB6 || op1_i == 8'hB7 ||
                   op1_i == 8'hBE || op1_i == 8'hBF) begin
        info_o.known = 1'b1; info_o.has_modrm = 1'b1;
      end
    end else begin
      info_o.op_len = 2'd1;
      if (op0_i <= 8'h3F) begin
        info_o.known = 1'b1;
        case (op0_i[2:0])
          3'd0, 3'd1, 3'd2, 3'd3: info_o.has_modrm = 1'b1;
          3'd4:                   info_o.imm = IMM_BYTE;
          3'd5:                   info_o.imm = IMM_FULL;
          default:                info_o.imm = IMM_NONE;
        endcase
      end else if ((op0_i >= 8'h40 && op0_i <= 8'h5F) ||
                   (op0_i >= 8'h90 && op0_i <= 8'h97) ||
                   (op0_i >= 8'hF8 && op0_i <= 8'hFD) ||
                   op0_i == 8'hC3 || op0_i == 8'hCC ||
                   op0_i == 8'hF4 || op0_i == 8'hF5) begin
        info_o.known = 1'b1;
      end else if (op0_i == 8'h68 || op0_i == 8'hA9 || op0_i == 8'hE8 ||
                   op0_i == 8'hE9 || op0_i[7:3] == 5'b10111) begin
        info_o.known = 1'b1; info_o.imm = IMM_FULL;
      end else if (op0_i == 8'h6A || op0_i[7:4] == 4'h7 || op0_i == 8'hA8 ||
                   op0_i[7:3] == 5'b10110 || op0_i == 8'hCD || op0_i == 8'hEB) begin
        info_o.known = 1'b1; info_o.imm = IMM_BYTE;
      end else if (op0_i == 8'hC2) begin
        info_o.known = 1'b1; info_o.imm = IMM_WORD;
      end else if (op0_i == 8'h69 || op0_i == 8'h81 || op0_i == 8'hC7) begin
        info_o.known = 1'b1; info_o.has_modrm = 1'b1; info_o.imm = IMM_FULL;
      end else if (op0_i == 8'h6B || op0_i == 8'h80 || op0_i == 8'h83 ||
                   op0_i == 8'hC6) begin
        info_o.known = 1'b1; info_o.has_modrm = 1'b1; info_o.imm = IMM_BYTE;
      end else if (op0_i == 8'hF6) begin
        info_o.known = 1'b1; info_o.has_modrm = 1'b1; info_o.imm = IMM_BYTE;
        info_o.imm_reg0 = 1'b1;
      end else if (op0_i == 8'hF7) begin
        info_o.known = 1'b1; info_o.has_modrm = 1'b1; info_o.imm = IMM_FULL;
        info_o.imm_reg0 = 1'b1;
      end else if ((op0_i >= 8'h84 && op0_i <= 8'h8F) ||
                   op0_i == 8'hFE || op0_i == 8'hFF) begin
        info_o.known = 1'b1; info_o.has_modrm = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ild_addr_fields.sv
module ild_addr_fields (
  input  logic       has_modrm_i,
  input  logic       addr16_i,
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  input  logic [2:0] sib_base_i,
  output logic       has_sib_o,
  output logic [2:0] disp_bytes_o
);

  always_comb begin
    has_sib_o    = 1'b0;
    disp_bytes_o = 3'd0;
    if (has_modrm_i && mod_i != 2'b11) begin
      if (addr16_i) begin
        if (mod_i == 2'b01)                          disp_bytes_o = 3'd1;
        else if (mod_i == 2'b10 || rm_i == 3'b110)   disp_bytes_o = 3'd2;
      end else begin
        has_sib_o = (rm_i == 3'b100);
        if (mod_i == 2'b01)                          disp_bytes_o = 3'd1;
        else if (mod_i == 2'b10)                     disp_bytes_o = 3'd4;
        else if (rm_i == 3'b101 ||
                 (rm_i == 3'b100 && sib_base_i == 3'b101)) disp_bytes_o = 3'd4;
      end
    end
  end

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder import ild_pkg::*; #(
  parameter int MAX_BYTES = 15
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [MAX_BYTES*8-1:0]       in_bytes,
  output logic                         out_valid,
  output logic [$clog2(MAX_BYTES+1)-1:0] out_len,
  output logic [$clog2(MAX_BYTES+1)-1:0] out_pfx_cnt,
  output logic [1:0]                   out_op_bytes,
  output logic                         out_has_modrm,
  output logic                         out_has_sib,
  output logic [2:0]                   out_disp_bytes,
  output logic [2:0]                   out_imm_bytes,
  output logic                         out_seg_ovr,
  output logic                         out_opsize,
  output logic                         out_adsize,
  output logic                         out_lock,
  output logic                         out_rep,
  output logic                         out_illegal,
  output logic                         out_unsupported
);

  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int SUM_W = $clog2(MAX_BYTES + 15);

  logic [CNT_W-1:0] npfx;
  pfx_flags_t       pflags;
  op_info_t         info;
  logic [7:0]       op0, op1, modrm;
  logic [2:0]       sib_base;
  logic             has_sib;
  logic [2:0]       disp_bytes, imm_bytes;
  logic [SUM_W-1:0] op_pos, modrm_pos, total;
  logic             no_opcode, too_long, unsupported;

  ild_prefix_scan #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_pfx (
    .bytes_i (in_bytes),
    .count_o (npfx),
    .flags_o (pflags)
  );

  assign op_pos    = SUM_W'(npfx);
  assign modrm_pos = op_pos + SUM_W'(info.op_len);

  // Field byte selection: positions past the window read as zero.
  always_comb begin
    op0 = 8'h00; op1 = 8'h00; modrm = 8'h00; sib_base = 3'd0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (op_pos == SUM_W'(k))               op0      = in_bytes[k*8 +: 8];
      if (op_pos + SUM_W'(1) == SUM_W'(k))   op1      = in_bytes[k*8 +: 8];
      if (modrm_pos == SUM_W'(k))            modrm    = in_bytes[k*8 +: 8];
      if (modrm_pos + SUM_W'(1) == SUM_W'(k)) sib_base = in_bytes[k*8 +: 3];
    end
  end

  ild_opcode_props u_ops (
    .op0_i  (op0),
    .op1_i  (op1),
    .info_o (info)
  );

  ild_addr_fields u_addr (
    .has_modrm_i  (info.has_modrm),
    .addr16_i     (pflags.adsz),
    .mod_i        (modrm[7:6]),
    .rm_i         (modrm[2:0]),
    .sib_base_i   (sib_base),
    .has_sib_o    (has_sib),
    .disp_bytes_o (disp_bytes)
  );

  always_comb begin
    case (info.imm)
      IMM_BYTE: imm_bytes = 3'd1;
      IMM_WORD: imm_bytes = 3'd2;
      IMM_FULL: imm_bytes = pflags.opsz ? 3'd2 : 3'd4;
      default:  imm_bytes = 3'd0;
    endcase
    if (info.imm_reg0 && modrm[5:3] != 3'b000) imm_bytes = 3'd0;
  end

  assign total = op_pos + SUM_W'(info.op_len) + SUM_W'(info.has_modrm) +
                 SUM_W'(has_sib) + SUM_W'(disp_bytes) + SUM_W'(imm_bytes);
  assign no_opcode   = (npfx == CNT_W'(MAX_BYTES));
  assign too_long    = (total > SUM_W'(MAX_BYTES));
  assign unsupported = !no_opcode && !info.known;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_len         <= '0;
      out_pfx_cnt     <= '0;
      out_op_bytes    <= '0;
      out_has_modrm   <= 1'b0;
      out_has_sib     <= 1'b0;
      out_disp_bytes  <= '0;
      out_imm_bytes   <= '0;
      out_seg_ovr     <= 1'b0;
      out_opsize      <= 1'b0;
      out_adsize      <= 1'b0;
      out_lock        <= 1'b0;
      out_rep         <= 1'b0;
      out_illegal     <= 1'b0;
      out_unsupported <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pfx_cnt     <= npfx;
        out_op_bytes    <= no_opcode ? 2'd0 : info.op_len;
        out_has_modrm   <= info.has_modrm && !no_opcode;
        out_has_sib     <= has_sib && !no_opcode;
        out_disp_bytes  <= no_opcode ? 3'd0 : disp_bytes;
        out_imm_bytes   <= no_opcode ? 3'd0 : imm_bytes;
        out_seg_ovr     <= pflags.seg;
        out_opsize      <= pflags.opsz;
        out_adsize      <= pflags.adsz;
        out_lock        <= pflags.lock;
        out_rep         <= pflags.rep;
        out_illegal     <= no_opcode || too_long;
        out_unsupported <= unsupported;
        out_len         <= (no_opcode || too_long || unsupported) ? '0 : total[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/ild_checker.sv
module ild_checker #(
  parameter int MAX_BYTES = 15
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          in_valid,
  input logic                          out_valid,
  input logic [$clog2(MAX_BYTES+1)-1:0] out_len,
  input logic [$clog2(MAX_BYTES+1)-1:0] out_pfx_cnt,
  input logic [1:0]                    out_op_bytes,
  input logic                          out_has_modrm,
  input logic                          out_has_sib,
  input logic [2:0]                    out_disp_bytes,
  input logic [2:0]                    out_imm_bytes,
  input logic                          out_opsize,
  input logic                          out_adsize,
  input logic                          out_illegal,
  input logic                          out_unsupported
);

  logic [7:0] field_sum;
  assign field_sum = 8'(out_pfx_cnt) + 8'(out_op_bytes) + 8'(out_has_modrm) +
                     8'(out_has_sib) + 8'(out_disp_bytes) + 8'(out_imm_bytes);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r5_sib_needs_modrm: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_has_sib) |-> out_has_modrm);
  a_r7_no_sib_16bit: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_adsize && !out_illegal) |-> !out_has_sib);
  a_r6_disp_sizes: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_disp_bytes == 3'd0 || out_disp_bytes == 3'd1 ||
                   out_disp_bytes == 3'd2 || out_disp_bytes == 3'd4));
  a_r10_imm_full_shrinks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_opsize) |-> (out_imm_bytes != 3'd4));
  a_r3_flag_needs_prefix: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_opsize || out_adsize)) |-> (out_pfx_cnt != '0));
  a_r12_len_is_sum: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && !out_unsupported) |-> (8'(out_len) == field_sum));
  a_r14_flagged_len_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_illegal || out_unsupported)) |-> (out_len == '0));

endmodule

bind insn_len_decoder ild_checker #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .out_valid       (out_valid),
  .out_len         (out_len),
  .out_pfx_cnt     (out_pfx_cnt),
  .out_op_bytes    (out_op_bytes),
  .out_has_modrm   (out_has_modrm),
  .out_has_sib     (out_has_sib),
  .out_disp_bytes  (out_disp_bytes),
  .out_imm_bytes   (out_imm_bytes),
  .out_opsize      (out_opsize),
  .out_adsize      (out_adsize),
  .out_illegal     (out_illegal),
  .out_unsupported (out_unsupported)
);

// File: tb/tb_insn_len_decoder.sv
module tb_insn_len_decoder;
  localparam int MAXB = 15;
  localparam int CW   = $clog2(MAXB + 1);

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [MAXB*8-1:0] in_bytes = '0;
  logic out_valid, out_has_modrm, out_has_sib, out_seg_ovr, out_opsize;
  logic out_adsize, out_lock, out_rep, out_illegal, out_unsupported;
  logic [CW-1:0] out_len, out_pfx_cnt;
  logic [1:0] out_op_bytes;
  logic [2:0] out_disp_bytes, out_imm_bytes;

  always #5 clk = ~clk;

  insn_len_decoder #(.MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_len(out_len), .out_pfx_cnt(out_pfx_cnt),
    .out_op_bytes(out_op_bytes), .out_has_modrm(out_has_modrm),
    .out_has_sib(out_has_sib), .out_disp_bytes(out_disp_bytes),
    .out_imm_bytes(out_imm_bytes), .out_seg_ovr(out_seg_ovr),
    .out_opsize(out_opsize), .out_adsize(out_adsize), .out_lock(out_lock),
    .out_rep(out_rep), .out_illegal(out_illegal), .out_unsupported(out_unsupported)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] bb [MAXB];

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int k = 0; k < MAXB; k++) bb[k] = 8'h00;
  endtask

  // Drive on a falling edge, result registered at the rising edge, read at the next falling edge.
  task automatic fire();
    @(negedge clk);
    for (int k = 0; k < MAXB; k++) in_bytes[k*8 +: 8] = bb[k];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic shape(string tag, int len, int pfx, int ob, int m, int s, int d, int i);
    chk(tag, "valid", int'(out_valid), 1);
    chk(tag, "len", int'(out_len), len);
    chk(tag, "pfx_cnt", int'(out_pfx_cnt), pfx);
    chk(tag, "op_bytes", int'(out_op_bytes), ob);
    chk(tag, "modrm", int'(out_has_modrm), m);
    chk(tag, "sib", int'(out_has_sib), s);
    chk(tag, "disp", int'(out_disp_bytes), d);
    chk(tag, "imm", int'(out_imm_bytes), i);
    chk(tag, "illegal", int'(out_illegal), 0);
    chk(tag, "unsupported", int'(out_unsupported), 0);
  endtask

  task automatic t_reset();
    chk("R1", "valid", int'(out_valid), 0);
    chk("R1", "len", int'(out_len), 0);
    chk("R1", "pfx_cnt", int'(out_pfx_cnt), 0);
    chk("R1", "illegal", int'(out_illegal), 0);
  endtask

  task automatic t_valid_timing();
    clr(); bb[0] = 8'h90;
    fire();
    shape("R12", 1, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R2", "valid after idle", int'(out_valid), 0);
    chk("R2", "len held", int'(out_len), 1);
  endtask

  task automatic t_prefixes();
    clr();
    bb[0] = 8'hF0; bb[1] = 8'h66; bb[2] = 8'h67; bb[3] = 8'hF2; bb[4] = 8'h26; bb[5] = 8'h90;
    fire();
    shape("R3", 6, 5, 1, 0, 0, 0, 0);
    chk("R3", "seg", int'(out_seg_ovr), 1);
    chk("R3", "opsize", int'(out_opsize), 1);
    chk("R3", "adsize", int'(out_adsize), 1);
    chk("R3", "lock", int'(out_lock), 1);
    chk("R3", "rep", int'(out_rep), 1);
    clr(); bb[0] = 8'h3E; bb[1] = 8'hF3; bb[2] = 8'h90;
    fire();
    shape("R3", 3, 2, 1, 0, 0, 0, 0);
    chk("R3", "seg", int'(out_seg_ovr), 1);
    chk("R3", "opsize clear", int'(out_opsize), 0);
    chk("R3", "lock clear", int'(out_lock), 0);
  endtask

  task automatic t_sib32();
    clr(); bb[0] = 8'h8B; bb[1] = 8'h04; bb[2] = 8'h24;
    fire(); shape("R5", 3, 0, 1, 1, 1, 0, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'hC4;
    fire(); shape("R5", 2, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_disp32();
    clr(); bb[0] = 8'h8B; bb[1] = 8'h44; bb[2] = 8'h24; bb[3] = 8'h08;
    fire(); shape("R6", 4, 0, 1, 1, 1, 1, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h05;
    fire(); shape("R6", 6, 0, 1, 1, 0, 4, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h04; bb[2] = 8'h25;
    fire(); shape("R6", 7, 0, 1, 1, 1, 4, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h80;
    fire(); shape("R6", 6, 0, 1, 1, 0, 4, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'hC0;
    fire(); shape("R6", 2, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_addr16();
    clr(); bb[0] = 8'h67; bb[1] = 8'h8B; bb[2] = 8'h06;
    fire(); shape("R7", 5, 1, 1, 1, 0, 2, 0);
    clr(); bb[0] = 8'h67; bb[1] = 8'h8B; bb[2] = 8'h04;
    fire(); shape("R7", 3, 1, 1, 1, 0, 0, 0);
    clr(); bb[0] = 8'h67; bb[1] = 8'h8B; bb[2] = 8'h44;
    fire(); shape("R7", 4, 1, 1, 1, 0, 1, 0);
    clr(); bb[0] = 8'h67; bb[1] = 8'h8B; bb[2] = 8'h84;
    fire(); shape("R7", 5, 1, 1, 1, 0, 2, 0);
  endtask

  task automatic t_imm();
    clr(); bb[0] = 8'h05;
    fire(); shape("R8", 5, 0, 1, 0, 0, 0, 4);
    clr(); bb[0] = 8'h04;
    fire(); shape("R8", 2, 0, 1, 0, 0, 0, 1);
    clr(); bb[0] = 8'h81; bb[1] = 8'hC0;
    fire(); shape("R8", 6, 0, 1, 1, 0, 0, 4);
    clr(); bb[0] = 8'hC2;
    fire(); shape("R8", 3, 0, 1, 0, 0, 0, 2);
    clr(); bb[0] = 8'h66; bb[1] = 8'h05;
    fire(); shape("R10", 4, 1, 1, 0, 0, 0, 2);
    clr(); bb[0] = 8'h66; bb[1] = 8'h6A;
    fire(); shape("R10", 3, 1, 1, 0, 0, 0, 1);
    clr(); bb[0] = 8'h66; bb[1] = 8'hC2;
    fire(); shape("R10", 4, 1, 1, 0, 0, 0, 2);
    clr(); bb[0] = 8'h66; bb[1] = 8'h81; bb[2] = 8'h05;
    fire(); shape("R10", 9, 1, 1, 1, 0, 4, 2);
  endtask

  task automatic t_escape();
    clr(); bb[0] = 8'h0F; bb[1] = 8'h84;
    fire(); shape("R9", 6, 0, 2, 0, 0, 0, 4);
    clr(); bb[0] = 8'h0F; bb[1] = 8'hB6; bb[2] = 8'hC0;
    fire(); shape("R9", 3, 0, 2, 1, 0, 0, 0);
    clr(); bb[0] = 8'h0F; bb[1] = 8'h38; bb[2] = 8'h00; bb[3] = 8'hC1;
    fire(); shape("R4", 4, 0, 3, 1, 0, 0, 0);
    clr(); bb[0] = 8'h0F; bb[1] = 8'h3A; bb[2] = 8'h0F; bb[3] = 8'hC1;
    fire(); shape("R4", 5, 0, 3, 1, 0, 0, 1);
  endtask

  task automatic t_group3();
    clr(); bb[0] = 8'hF7; bb[1] = 8'hC0;
    fire(); shape("R11", 6, 0, 1, 1, 0, 0, 4);
    clr(); bb[0] = 8'hF7; bb[1] = 8'hD8;
    fire(); shape("R11", 2, 0, 1, 1, 0, 0, 0);
    clr(); bb[0] = 8'hF6; bb[1] = 8'hC0;
    fire(); shape("R11", 3, 0, 1, 1, 0, 0, 1);
    clr(); bb[0] = 8'hF6; bb[1] = 8'hD0;
    fire(); shape("R11", 2, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_length_limit();
    clr();
    for (int k = 0; k < 14; k++) bb[k] = 8'h66;
    bb[14] = 8'h90;
    fire(); shape("R12", 15, 14, 1, 0, 0, 0, 0);
    bb[14] = 8'h04;
    fire();
    chk("R12", "illegal 16 bytes", int'(out_illegal), 1);
    chk("R12", "len 16 bytes", int'(out_len), 0);
    clr();
    bb[0] = 8'hF0; bb[1] = 8'h2E; bb[2] = 8'h36; bb[3] = 8'h3E; bb[4] = 8'h64;
    bb[5] = 8'h65; bb[6] = 8'h26; bb[7] = 8'h81; bb[8] = 8'h84; bb[9] = 8'h24;
    fire();
    chk("R12", "illegal 18 bytes", int'(out_illegal), 1);
    chk("R12", "len 18 bytes", int'(out_len), 0);
  endtask

  task automatic t_all_prefix();
    clr();
    for (int k = 0; k < MAXB; k++) bb[k] = 8'hF3;
    fire();
    chk("R13", "illegal", int'(out_illegal), 1);
    chk("R13", "pfx_cnt", int'(out_pfx_cnt), 15);
    chk("R13", "len", int'(out_len), 0);
  endtask

  task automatic t_unsupported();
    clr(); bb[0] = 8'hD8; bb[1] = 8'hC0;
    fire();
    chk("R14", "unsupported D8", int'(out_unsupported), 1);
    chk("R14", "len D8", int'(out_len), 0);
    clr(); bb[0] = 8'h0F; bb[1] = 8'h0B;
    fire();
    chk("R14", "unsupported 0F0B", int'(out_unsupported), 1);
    chk("R14", "len 0F0B", int'(out_len), 0);
    chk("R14", "not illegal", int'(out_illegal), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_valid_timing();
    t_prefixes();
    t_sib32();
    t_disp32();
    t_addr16();
    t_imm();
    t_escape();
    t_group3();
    t_length_limit();
    t_all_prefix();
    t_unsupported();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule